// File: doc/BRIEF.md
# Triggered Autoscan Conversion Sequencer

This block tells an analog-to-digital converter when to start a conversion and which of 16 multiplexer inputs to sample. A small register write port sets it up. A 6-bit trigger setup field picks where conversion starts come from. The possible sources are a software write, a one-cycle tick from an external pacer timer, or the rising edge of an asynchronous trigger pin. The same field holds the autoscan and pretrigger enables and two further flag bits. A channel field holds one of two things: the single input to convert, or, when autoscan is on, the highest input of a scan that always begins at input 0. A 3-bit gain field applies to every channel in a scan.

Each accepted trigger gives a one-cycle `conv_start` pulse. In the same cycle, `conv_chan` shows the input to convert. With autoscan on, successive conversions walk 0, 1, … up to the limit and then wrap back to 0. The pacer timer and the converter are outside this block. The pacer period is a multiple of 500 ns with a 10 µs minimum conversion period, so pacer ticks arrive far apart in clock cycles.

Top module: `autoscan_seq`

## Requirements
- R1: After reset, `conv_start`, `conv_chan`, `trig_cfg` and `conv_gain` are all 0.
- R2: A write to address 0 loads `trig_cfg` from `wr_data[5:0]`. Bit 0 is autoscan, bit 1 is pacer select, bit 2 is external select, bit 3 is pretrigger, and bits 4 and 5 are flags. A write to address 2 loads `conv_gain` from `wr_data[2:0]`. A write to address 1 loads the channel field from `wr_data[3:0]`. A register write takes effect on the clock edge that samples it.
- R3: When bits 1 and 2 are both 0, the only trigger is a write of any data to address 3. `conv_start` is high for exactly the one cycle that follows the edge sampling that write. No other stimulus starts a conversion.
- R4: A write to address 3 starts nothing while bit 1 or bit 2 is set.
- R5: When bit 1 is set, a `pacer_tick` sampled high raises `conv_start` for the following cycle. In software mode, `pacer_tick` has no effect.
- R6: When bit 2 is set and bit 1 is clear, a rising edge on `ext_trig` gives one `conv_start` pulse, in the cycle after the third clock edge that sees the new level. Holding `ext_trig` high gives no further pulses.
- R7: When bits 1 and 2 are both set, the pacer is the source and `ext_trig` is ignored.
- R8: With autoscan off, each conversion reports the channel field on `conv_chan`.
- R9: With autoscan on and limit L in the channel field, successive conversions report 0, 1, …, L and then start again at 0.
- R10: The scan position returns to 0 when the channel field is written or autoscan is turned off.
- R11: `conv_chan` changes only in a cycle where `conv_start` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 trigger setup, 1 channel, 2 gain, 3 software trigger |
| wr_data | input | 6 | Write data |
| pacer_tick | input | 1 | One-cycle tick from the pacer timer |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_gain | output | 3 | Shared gain range code |
| trig_cfg | output | 6 | Current trigger setup field |

## Verification
The bench sweeps every scan limit from 0 to 15, and runs each one through more than two full scans. A counter that wrapped one step early or late, or that never wrapped at limit 0, shows up in those sweeps. It also converts every fixed channel.

The external path is checked cycle by cycle. A synchroniser with a missing or extra stage would move the pulse off its expected cycle. A level-sensitive trigger would repeat while the pin is held high.

Cross-mode stimulus checks the other corner cases:
- software writes in pacer and external modes, which must do nothing;
- pacer ticks in software mode, which must do nothing;
- an external edge with both source bits set, which must do nothing.

Finally, the bench rewrites the channel field and toggles autoscan in the middle of a scan, to catch a position that is not cleared.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int CFG_W = 6;

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_CHAN = 2'd1,
        A_GAIN = 2'd2,
        A_SOFT = 2'd3
    } reg_addr_e;

    // packed: last member is bit 0
    typedef struct packed {
        logic trig_evt;   // bit 5
        logic post_trig;  // bit 4
        logic pre_trig;   // bit 3
        logic ext_sel;    // bit 2
        logic pacer_sel;  // bit 1
        logic autoscan;   // bit 0
    } trig_cfg_t;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_PACER = 2'd1,
        SRC_EXT   = 2'd2
    } src_e;

    // pacer outranks external; neither means software only
    function automatic src_e pick_src(trig_cfg_t c);
        if (c.pacer_sel)    return SRC_PACER;
        else if (c.ext_sel) return SRC_EXT;
        else                return SRC_SOFT;
    endfunction

endpackage

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int GAIN_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [CFG_W-1:0]    wr_data,
    output trig_cfg_t           cfg,
    output logic [CH_W-1:0]     chan_reg,
    output logic [GAIN_W-1:0]   gain_reg,
    output logic                soft_strobe,
    output logic                chan_wr
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(wr_addr);

    assign soft_strobe = wr_en && (addr == A_SOFT);
    assign chan_wr     = wr_en && (addr == A_CHAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            chan_reg <= '0;
            gain_reg <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CFG:   cfg      <= trig_cfg_t'(wr_data);
                A_CHAN:  chan_reg <= wr_data[CH_W-1:0];
                A_GAIN:  gain_reg <= wr_data[GAIN_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/seq_trig.sv
module seq_trig
    import seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  trig_cfg_t cfg,
    input  logic      soft_strobe,
    input  logic      pacer_tick,
    input  logic      ext_async,
    output logic      fire,
    output logic      ext_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= ext_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b0;
                    else     sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] && !prev_q;

    src_e src;
    assign src = pick_src(cfg);

    always_comb begin
        case (src)
            SRC_SOFT:  fire = soft_strobe;
            SRC_PACER: fire = pacer_tick;
            SRC_EXT:   fire = ext_rise;
            default:   fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq_chan_ctr.sv
module seq_chan_ctr #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            step,
    input  logic [CH_W-1:0] limit,
    output logic [CH_W-1:0] cur
);

    always_ff @(posedge clk) begin
        if (rst || clear)  cur <= '0;
        else if (step)     cur <= (cur >= limit) ? '0 : cur + 1'b1;
    end

endmodule

// File: rtl/autoscan_seq.sv
module autoscan_seq
    import seq_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int GAIN_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [CFG_W-1:0]          wr_data,
    input  logic                      pacer_tick,
    input  logic                      ext_trig,
    output logic                      conv_start,
    output logic [$clog2(NUM_CH)-1:0] conv_chan,
    output logic [GAIN_W-1:0]         conv_gain,
    output logic [CFG_W-1:0]          trig_cfg
);

    localparam int CH_W = $clog2(NUM_CH);

    trig_cfg_t       cfg;
    logic [CH_W-1:0] chan_reg;
    logic [CH_W-1:0] scan_cur;
    logic            soft_strobe;
    logic            chan_wr;
    logic            fire;
    logic            ext_rise;

    seq_regs #(.CH_W(CH_W), .GAIN_W(GAIN_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cfg         (cfg),
        .chan_reg    (chan_reg),
        .gain_reg    (conv_gain),
        .soft_strobe (soft_strobe),
        .chan_wr     (chan_wr)
    );

    seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .soft_strobe (soft_strobe),
        .pacer_tick  (pacer_tick),
        .ext_async   (ext_trig),
        .fire        (fire),
        .ext_rise    (ext_rise)
    );

    seq_chan_ctr #(.CH_W(CH_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (chan_wr || !cfg.autoscan),
        .step  (fire && cfg.autoscan),
        .limit (chan_reg),
        .cur   (scan_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= fire;
            if (fire) conv_chan <= cfg.autoscan ? scan_cur : chan_reg;
        end
    end

    assign trig_cfg = CFG_W'(cfg);

endmodule

// File: rtl/autoscan_seq_chk.sv
module autoscan_seq_chk
    import seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_chan,
    input trig_cfg_t       cfg,
    input logic [CH_W-1:0] chan_reg,
    input logic            soft_strobe,
    input logic            pacer_tick
);

    p_sw_only_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!cfg.pacer_sel && !cfg.ext_sel) && !$past(soft_strobe)) |-> !conv_start);

    p_pacer_prio_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg.pacer_sel) && !$past(pacer_tick)) |-> !conv_start);

    p_fixed_chan_r8: assert property (@(posedge clk) disable iff (rst)
        (conv_start && $past(!cfg.autoscan)) |-> (conv_chan == $past(chan_reg)));

    p_scan_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (conv_start && $past(cfg.autoscan)) |-> (conv_chan <= $past(chan_reg)));

    p_chan_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !conv_start |-> $stable(conv_chan));

endmodule

bind autoscan_seq autoscan_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .cfg         (cfg),
    .chan_reg    (chan_reg),
    .soft_strobe (soft_strobe),
    .pacer_tick  (pacer_tick)
);

// File: tb/autoscan_seq_test.sv
module autoscan_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic       pacer_tick = 1'b0;
    logic       ext_trig = 1'b0;
    logic       conv_start;
    logic [3:0] conv_chan;
    logic [2:0] conv_gain;
    logic [5:0] trig_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    autoscan_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_gain(conv_gain), .trig_cfg(trig_cfg)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // software trigger; returns start and channel in the following cycle
    task automatic soft_fire(output logic st, output logic [3:0] ch);
        @(negedge clk); wr_en = 1'b1; wr_addr = 2'd3; wr_data = 6'h25;
        @(posedge clk); #1 st = conv_start; ch = conv_chan;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pacer_fire(output logic st, output logic [3:0] ch);
        @(negedge clk); pacer_tick = 1'b1;
        @(posedge clk); #1 st = conv_start; ch = conv_chan;
        @(negedge clk); pacer_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic st;
        logic [3:0] ch;
        int cnt;
        logic e0, e1, e2;

        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check(conv_start, 0, "R1 start");
        check(conv_chan, 0, "R1 chan");
        check(trig_cfg, 0, "R1 cfg");
        check(conv_gain, 0, "R1 gain");

        // R2 register loads
        wr(2'd0, 6'b111000); #1 check(trig_cfg, 6'b111000, "R2 cfg");
        wr(2'd2, 6'b000101); #1 check(conv_gain, 5, "R2 gain");
        wr(2'd0, 6'b000000); #1 check(trig_cfg, 0, "R2 cfg clear");

        // R3 + R8: fixed channel sweep in software mode
        for (int c = 0; c < 16; c++) begin
            wr(2'd1, 6'(c));
            soft_fire(st, ch);
            check(st, 1, "R3 soft start");
            check(ch, c, "R8 fixed chan");
            @(posedge clk); #1 check(conv_start, 0, "R3 single pulse");
        end

        // R5: pacer ignored in software mode
        pacer_fire(st, ch);
        check(st, 0, "R5 pacer ignored in soft mode");

        // R9: every scan limit, more than two passes
        for (int lim = 0; lim < 16; lim++) begin
            wr(2'd1, 6'(lim));
            wr(2'd0, 6'b000001);
            for (int n = 0; n < 2 * lim + 3; n++) begin
                soft_fire(st, ch);
                check(st, 1, "R9 start");
                check(ch, n % (lim + 1), "R9 scan order");
            end
            wr(2'd0, 6'b000000);
        end

        // R10: rewrite channel mid-scan, then toggle autoscan
        wr(2'd1, 6'd5);
        wr(2'd0, 6'b000001);
        for (int n = 0; n < 3; n++) soft_fire(st, ch);
        check(ch, 2, "R10 pre");
        wr(2'd1, 6'd5);
        soft_fire(st, ch);
        check(ch, 0, "R10 after chan write");
        soft_fire(st, ch); soft_fire(st, ch);
        check(ch, 2, "R10 resume");
        wr(2'd0, 6'b000000);
        wr(2'd0, 6'b000001);
        soft_fire(st, ch);
        check(ch, 0, "R10 after autoscan off");

        // R5 pacer mode with autoscan, R4 soft ignored
        wr(2'd1, 6'd3);
        wr(2'd0, 6'b000011);
        for (int n = 0; n < 6; n++) begin
            pacer_fire(st, ch);
            check(st, 1, "R5 pacer start");
            check(ch, n % 4, "R5 pacer scan");
        end
        soft_fire(st, ch);
        check(st, 0, "R4 soft ignored in pacer mode");
        @(posedge clk); #1 check(conv_start, 0, "R4 no late start");

        // R6 external mode
        wr(2'd0, 6'b000100);
        wr(2'd1, 6'd9);
        soft_fire(st, ch);
        check(st, 0, "R4 soft ignored in ext mode");
        pacer_fire(st, ch);
        check(st, 0, "R6 pacer ignored in ext mode");
        for (int rep = 0; rep < 3; rep++) begin
            @(negedge clk); ext_trig = 1'b1;
            @(posedge clk); #1 e0 = conv_start;
            @(posedge clk); #1 e1 = conv_start;
            @(posedge clk); #1 e2 = conv_start;
            check(e0, 0, "R6 edge1");
            check(e1, 0, "R6 edge2");
            check(e2, 1, "R6 edge3 start");
            check(conv_chan, 9, "R6 chan");
            cnt = 0;
            for (int k = 0; k < 6; k++) begin
                @(posedge clk); #1 if (conv_start) cnt++;
            end
            check(cnt, 0, "R6 held level no retrigger");
            @(negedge clk); ext_trig = 1'b0;
            repeat (4) @(posedge clk);
        end

        // R7 both source bits: pacer wins, ext ignored
        wr(2'd0, 6'b000110);
        @(negedge clk); ext_trig = 1'b1;
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1 if (conv_start) cnt++;
        end
        check(cnt, 0, "R7 ext ignored");
        @(negedge clk); ext_trig = 1'b0;
        pacer_fire(st, ch);
        check(st, 1, "R7 pacer works");

        // R11: channel holds while idle
        ch = conv_chan;
        repeat (5) @(posedge clk);
        #1 check(conv_chan, ch, "R11 hold");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule